// File: doc/BRIEF.md
# Character Serializer with Pad Fill and Lane Blanking

This block turns a stream of transmission characters into a serial bit stream. It runs on the bit clock. An internal ten-phase counter defines the character slots, and `char_strobe` marks the last bit time of each slot. At the clock edge that ends a strobe cycle, the block samples the host inputs. It then shifts the resulting 10-bit character out, first bit first, over the next ten bit times.

The block has two ways to form a character:
- **Encoded mode:** the host supplies a byte and a control flag. An 8b/10b encoder that tracks running disparity turns it into a 10-bit character.
- **Raw mode:** the host word goes out untouched.

When neither enable is active at a load edge, the block sends a K28.5 pad character instead. The pad takes the form that matches the current running disparity.

The serial stream is copied to three complementary lane pairs. A blanking input forces lanes A and B dark, for use when laser output must be off. Lane C keeps carrying the live stream for diagnostic loopback. Blanking changes only the lane outputs; it never affects character framing or disparity.

Top module: `ser_tx_top`

## Requirements
- R1: A character lasts exactly 10 bit-clock cycles. `char_strobe` is high only in the tenth cycle of each character. The inputs are sampled at the edge that ends a strobe cycle, and bit 0 of the loaded 10-bit word (code bit "a") is sent first.
- R2: A synchronous reset (`rst_n` low at a clock edge) restarts the character slot. It loads the negative-disparity pad 0,0,1,1,1,1,1,0,1,0 (in send order), and the running disparity that follows is positive.
- R3: A character is taken from the host when `tx_en_a_n` or `tx_en_b_n` is low at the load edge. Holding either one low therefore means no pad is ever inserted.
- R4: When both enables are high at a load edge, a K28.5 pad is sent: 0,0,1,1,1,1,1,0,1,0 if the disparity is negative, 1,1,0,0,0,0,0,1,0,1 if it is positive. Every pad inverts the disparity, so back-to-back pads alternate form.
- R5: In encoded mode (`raw_mode` low), `tx_word[7:0]` is encoded as 8b/10b using the running disparity. With `tx_k` high, the character is the control character K28.y, where y is `tx_word[7:5]`. Examples in send order from negative disparity:
  - D0.0 = 1001110100
  - D17.7 = 1000110111 (disparity becomes positive)
  - D21.5 = 1010101010

  From positive disparity, D0.0 = 0110001011.
- R6: In raw mode with an enable active, `tx_word[9:0]` is sent as given, bit 0 first, and the running disparity is left unchanged. A later pad therefore uses the disparity from before the raw characters. An all-zero word holds every live lane's true output low for the whole character.
- R7: From the first clock edge that samples `blank_ab` high, lanes A and B show true output low and complement output high. This holds until an edge samples it low.
- R8: Lane C ignores `blank_ab`. It always carries the serial stream with its complement output inverted, and blanking does not disturb character framing or content.
- R9: After an edge that samples `blank_ab` low, lanes A, B and C carry identical values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en_a_n | input | 1 | Host enable, active low |
| tx_en_b_n | input | 1 | Second host enable, active low |
| raw_mode | input | 1 | 1 = send tx_word unencoded |
| tx_k | input | 1 | Encoded mode: send K28.y control character |
| tx_word | input | 10 | Host character; [7:0] is the byte in encoded mode |
| blank_ab | input | 1 | Forces lanes A and B dark |
| char_strobe | output | 1 | High in the last bit time of each character |
| lane_a_p | output | 1 | Lane A true output |
| lane_a_n | output | 1 | Lane A complement output |
| lane_b_p | output | 1 | Lane B true output |
| lane_b_n | output | 1 | Lane B complement output |
| lane_c_p | output | 1 | Lane C true output |
| lane_c_n | output | 1 | Lane C complement output |

## Verification
The assertions assume that host inputs are stable around each rising edge. They also assume that the enables, mode and word matter only at strobe edges, so the disparity and pad properties look only at those edges. The encoder is assumed to see K flags only for the K28 family, and data bytes are assumed to be legal. The stimulus changes every input on the falling edge: host fields only in the strobe cycle, and blanking at arbitrary mid-character points. It uses bytes whose 8b/10b codes and disparity effects are listed in the requirements, so expected characters come straight from those values.

// File: rtl/ser_tx_pkg.sv
// Package: shared widths, pad constants and 8b/10b sub-block lookups.
// Assumes code words are written here with code bit "a" as the MSB.
package ser_tx_pkg;
    localparam int CHAR_W  = 10;
    localparam int BYTE_W  = 8;
    localparam int NLANES  = 3;
    localparam logic [BYTE_W-1:0] PAD_BYTE = 8'hBC;            // K28.5 with k=1
    // K28.5 negative-disparity form, stored with code bit "a" at bit 0
    localparam logic [CHAR_W-1:0] PAD_NEG_WORD = 10'b0101111100;

    // 5b/6b lookup, negative-disparity column, result abcdei (a = MSB)
    function automatic logic [5:0] code6(input logic [4:0] x);
        logic [5:0] r;
        case (x)
            5'd0:  r = 6'b100111;  5'd1:  r = 6'b011101;
            5'd2:  r = 6'b101101;  5'd3:  r = 6'b110001;
            5'd4:  r = 6'b110101;  5'd5:  r = 6'b101001;
            5'd6:  r = 6'b011001;  5'd7:  r = 6'b111000;
            5'd8:  r = 6'b111001;  5'd9:  r = 6'b100101;
            5'd10: r = 6'b010101;  5'd11: r = 6'b110100;
            5'd12: r = 6'b001101;  5'd13: r = 6'b101100;
            5'd14: r = 6'b011100;  5'd15: r = 6'b010111;
            5'd16: r = 6'b011011;  5'd17: r = 6'b100011;
            5'd18: r = 6'b010011;  5'd19: r = 6'b110010;
            5'd20: r = 6'b001011;  5'd21: r = 6'b101010;
            5'd22: r = 6'b011010;  5'd23: r = 6'b111010;
            5'd24: r = 6'b110011;  5'd25: r = 6'b100110;
            5'd26: r = 6'b010110;  5'd27: r = 6'b110110;
            5'd28: r = 6'b001110;  5'd29: r = 6'b101110;
            5'd30: r = 6'b011110;  default: r = 6'b101011;
        endcase
        return r;
    endfunction

    // 3b/4b lookup, negative-disparity column, result fghj (f = MSB), primary .7
    function automatic logic [3:0] code4(input logic [2:0] y);
        logic [3:0] r;
        case (y)
            3'd0: r = 4'b1011;  3'd1: r = 4'b1001;
            3'd2: r = 4'b0101;  3'd3: r = 4'b1100;
            3'd4: r = 4'b1101;  3'd5: r = 4'b1010;
            3'd6: r = 4'b0110;  default: r = 4'b1110;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ser_tx_enc.sv
// 8b/10b encoder, purely combinational.
// Assumes k_in is used only for the K28.y family; rd_in 1 = positive disparity.
// The output word carries code bit "a" at bit 0, ready for LSB-first shifting.
module ser_tx_enc
    import ser_tx_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              k_in,
    input  logic              rd_in,
    output logic [CHAR_W-1:0] word_out,
    output logic              rd_out
);
    logic [4:0] x;
    logic [2:0] y;
    logic [5:0] raw6, c6;
    logic [3:0] raw4, c4;
    logic [2:0] ones6, ones4;
    logic       rd_mid, alt7;
    logic [CHAR_W-1:0] msb_first;

    assign x = byte_in[4:0];
    assign y = byte_in[7:5];

    // Six-bit sub-block and mid-character disparity
    always_comb begin
        raw6   = k_in ? 6'b001111 : code6(x);
        ones6  = 3'($countones(raw6));
        c6     = (rd_in && (ones6 != 3'd3 || raw6 == 6'b111000)) ? ~raw6 : raw6;
        rd_mid = (ones6 != 3'd3) ? ~rd_in : rd_in;
    end

    // Four-bit sub-block, alternate .7 selection and final disparity
    always_comb begin
        alt7 = k_in || (!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20))
                    || ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14));
        raw4  = (y == 3'd7 && alt7) ? 4'b0111 : code4(y);
        ones4 = 3'($countones(raw4));
        if (k_in && ones4 == 3'd2 && y != 3'd3)
            c4 = rd_mid ? raw4 : ~raw4;
        else
            c4 = (rd_mid && (ones4 != 3'd2 || y == 3'd3)) ? ~raw4 : raw4;
        rd_out = (ones4 != 3'd2) ? ~rd_mid : rd_mid;
    end

    // Reorder so that code bit "a" lands at bit 0
    assign msb_first = {c6, c4};
    always_comb begin
        for (int i = 0; i < CHAR_W; i++)
            word_out[i] = msb_first[CHAR_W-1-i];
    end
endmodule

// File: rtl/ser_tx_shift.sv
// Character shifter: a W-phase slot counter and an LSB-first shift register.
// Assumes load_word is valid in the cycle where last_slot is high.
module ser_tx_shift #(
    parameter int              W          = 10,
    parameter logic [W-1:0]    RESET_WORD = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] load_word,
    output logic         ser_bit,
    output logic         last_slot
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] phase_q;
    logic [W-1:0]  sreg_q;

    assign last_slot = (phase_q == LAST);
    assign ser_bit   = sreg_q[0];

    // Advance the slot counter, wrapping after the last bit time
    always_ff @(posedge clk) begin
        if (!rst_n)         phase_q <= '0;
        else if (last_slot) phase_q <= '0;
        else                phase_q <= phase_q + 1'b1;
    end

    // Reload at the slot boundary, otherwise shift toward bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)         sreg_q <= RESET_WORD;
        else if (last_slot) sreg_q <= load_word;
        else                sreg_q <= {1'b0, sreg_q[W-1:1]};
    end
endmodule

// File: rtl/ser_tx_lanes.sv
// Lane fan-out: copies the serial bit to N complementary pairs and darkens
// the lanes selected by MASK while the registered blank request is set.
// Assumes blank may change at any time; it acts from the next bit edge.
module ser_tx_lanes #(
    parameter int             N    = 3,
    parameter logic [N-1:0]   MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_bit,
    input  logic         blank,
    output logic [N-1:0] out_p,
    output logic [N-1:0] out_n
);
    logic blank_q;

    // Align the blank request to the bit boundary
    always_ff @(posedge clk) begin
        if (!rst_n) blank_q <= 1'b0;
        else        blank_q <= blank;
    end

    for (genvar i = 0; i < N; i++) begin : g_lane
        if (MASK[i]) begin : g_gated
            assign out_p[i] = ser_bit & ~blank_q;
        end else begin : g_live
            assign out_p[i] = ser_bit;
        end
        assign out_n[i] = ~out_p[i];
    end
endmodule

// File: rtl/ser_tx_top.sv
// Serializer top: host character selection, pad fill, running disparity,
// shifter and three-lane output with blanking of lanes A and B.
// Assumes host inputs are held stable across the edge ending char_strobe.
module ser_tx_top
    import ser_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en_a_n,
    input  logic              tx_en_b_n,
    input  logic              raw_mode,
    input  logic              tx_k,
    input  logic [CHAR_W-1:0] tx_word,
    input  logic              blank_ab,
    output logic              char_strobe,
    output logic              lane_a_p,
    output logic              lane_a_n,
    output logic              lane_b_p,
    output logic              lane_b_n,
    output logic              lane_c_p,
    output logic              lane_c_n
);
    localparam logic [NLANES-1:0] BLANK_SEL = 3'b011;   // lanes A and B

    logic              host_en, raw_sel, rd_q, enc_rd, ser_bit;
    logic [BYTE_W-1:0] enc_byte;
    logic              enc_k;
    logic [CHAR_W-1:0] enc_word, load_word;
    logic [NLANES-1:0] lp, ln;

    assign host_en  = !tx_en_a_n || !tx_en_b_n;
    assign raw_sel  = host_en && raw_mode;
    assign enc_byte = host_en ? tx_word[BYTE_W-1:0] : PAD_BYTE;
    assign enc_k    = host_en ? tx_k : 1'b1;

    ser_tx_enc u_enc (
        .byte_in  (enc_byte),
        .k_in     (enc_k),
        .rd_in    (rd_q),
        .word_out (enc_word),
        .rd_out   (enc_rd)
    );

    assign load_word = raw_sel ? tx_word : enc_word;

    // Running disparity: positive after the reset pad, frozen by raw characters
    always_ff @(posedge clk) begin
        if (!rst_n)                      rd_q <= 1'b1;
        else if (char_strobe && !raw_sel) rd_q <= enc_rd;
    end

    ser_tx_shift #(.W(CHAR_W), .RESET_WORD(PAD_NEG_WORD)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_word (load_word),
        .ser_bit   (ser_bit),
        .last_slot (char_strobe)
    );

    ser_tx_lanes #(.N(NLANES), .MASK(BLANK_SEL)) u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_bit (ser_bit),
        .blank   (blank_ab),
        .out_p   (lp),
        .out_n   (ln)
    );

    assign lane_a_p = lp[0];
    assign lane_a_n = ln[0];
    assign lane_b_p = lp[1];
    assign lane_b_n = ln[1];
    assign lane_c_p = lp[2];
    assign lane_c_n = ln[2];
endmodule

// File: rtl/ser_tx_chk.sv
// Checker: timing and lane properties of ser_tx_top, attached by bind.
// Assumes it observes the top's ports and its running-disparity register.
module ser_tx_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tx_en_a_n,
    input logic         tx_en_b_n,
    input logic         raw_mode,
    input logic [W-1:0] tx_word,
    input logic         blank_ab,
    input logic         char_strobe,
    input logic         lane_a_p,
    input logic         lane_a_n,
    input logic         lane_b_p,
    input logic         lane_b_n,
    input logic         lane_c_p,
    input logic         rd_q
);
    localparam int CW = $clog2(W);
    logic [CW-1:0] cnt_q;
    logic          idle, fed;

    assign idle = tx_en_a_n && tx_en_b_n;
    assign fed  = !idle;

    // Independent slot counter mirroring the character period
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (cnt_q == CW'(W - 1))   cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
    end

    assert_strobe_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        char_strobe == (cnt_q == CW'(W - 1)));

    assert_pad_flips_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (char_strobe && idle) |=> (rd_q != $past(rd_q)));

    assert_raw_keeps_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (char_strobe && fed && raw_mode) |=> $stable(rd_q));

    assert_raw_zero_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (char_strobe && fed && raw_mode && tx_word == '0) |=> !lane_c_p);

    assert_blank_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blank_ab |=> (!lane_a_p && lane_a_n && !lane_b_p && lane_b_n));

    assert_lanes_equal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_ab |=> (lane_a_p == lane_c_p && lane_b_p == lane_c_p));
endmodule

bind ser_tx_top ser_tx_chk #(.W(10)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en_a_n   (tx_en_a_n),
    .tx_en_b_n   (tx_en_b_n),
    .raw_mode    (raw_mode),
    .tx_word     (tx_word),
    .blank_ab    (blank_ab),
    .char_strobe (char_strobe),
    .lane_a_p    (lane_a_p),
    .lane_a_n    (lane_a_n),
    .lane_b_p    (lane_b_p),
    .lane_b_n    (lane_b_n),
    .lane_c_p    (lane_c_p),
    .rd_q        (rd_q)
);

// File: tb/tb_ser_tx_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected characters, a monitor
// rebuilds characters from lane C and checks lanes, strobe and framing.
module tb_ser_tx_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en_a_n = 1'b1, tx_en_b_n = 1'b1;
    logic       raw_mode = 1'b0, tx_k = 1'b0, blank_ab = 1'b0;
    logic [9:0] tx_word = '0;
    logic       char_strobe, lane_a_p, lane_a_n, lane_b_p, lane_b_n, lane_c_p, lane_c_n;

    int   errors = 0, checks = 0;
    bit   done = 0, mon_on = 0;
    logic m_rd = 1'b1;                 // bench disparity model, 1 = positive
    logic blank_seen = 1'b0;
    logic [9:0] exp_q[$];
    string      tag_q[$];
    logic [9:0] cap;
    int         idx = 0;

    always #2.5 clk = ~clk;

    ser_tx_top dut (
        .clk(clk), .rst_n(rst_n), .tx_en_a_n(tx_en_a_n), .tx_en_b_n(tx_en_b_n),
        .raw_mode(raw_mode), .tx_k(tx_k), .tx_word(tx_word), .blank_ab(blank_ab),
        .char_strobe(char_strobe), .lane_a_p(lane_a_p), .lane_a_n(lane_a_n),
        .lane_b_p(lane_b_p), .lane_b_n(lane_b_n), .lane_c_p(lane_c_p), .lane_c_n(lane_c_n)
    );

    function automatic logic [9:0] flip10(input logic [9:0] w);
        logic [9:0] r;
        for (int i = 0; i < 10; i++) r[i] = w[9-i];
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected pad per bench disparity; each pad inverts disparity (R4)
    function automatic logic [9:0] next_pad();
        logic [9:0] w;
        w = m_rd ? flip10(10'b1100000101) : flip10(10'b0011111010);
        m_rd = ~m_rd;
        return w;
    endfunction

    // Expected codes for the bytes this bench uses (R5)
    function automatic logic [9:0] enc_exp(input logic [7:0] b, input logic k);
        logic [9:0] w;
        if (k) return next_pad();
        case (b)
            8'h00:   w = m_rd ? 10'b0110001011 : 10'b1001110100;
            8'hB5:   w = 10'b1010101010;
            default: begin
                w = m_rd ? 10'b1000110001 : 10'b1000110111;
                m_rd = ~m_rd;
            end
        endcase
        return flip10(w);
    endfunction

    task automatic wait_slot();
        @(negedge clk);
        while (!char_strobe) @(negedge clk);
    endtask

    task automatic push(input logic [9:0] w, input string tag);
        exp_q.push_back(w);
        tag_q.push_back(tag);
    endtask

    task automatic send_enc(input logic ea_n, input logic eb_n, input logic [7:0] b,
                            input logic k, input string tag);
        wait_slot();
        tx_en_a_n = ea_n; tx_en_b_n = eb_n; raw_mode = 1'b0; tx_k = k; tx_word = {2'b00, b};
        push(enc_exp(b, k), tag);
    endtask

    task automatic send_raw(input logic [9:0] w, input string tag);
        wait_slot();
        tx_en_a_n = 1'b0; tx_en_b_n = 1'b1; raw_mode = 1'b1; tx_k = 1'b0; tx_word = w;
        push(w, tag);
    endtask

    task automatic send_idle(input logic raw, input string tag);
        wait_slot();
        tx_en_a_n = 1'b1; tx_en_b_n = 1'b1; raw_mode = raw; tx_word = 10'h3FF;
        push(next_pad(), tag);
    endtask

    always @(posedge clk) blank_seen <= blank_ab;

    // Monitor: per-bit lane checks, per-character scoreboard compare
    always @(negedge clk) begin
        if (mon_on) begin
            cap[idx] = lane_c_p;
            check(char_strobe == (idx == 9), "R1 strobe", 32'(char_strobe), 32'(idx == 9));
            check(lane_c_n == !lane_c_p, "R8 lane C pair", 32'(lane_c_n), 32'(!lane_c_p));
            if (blank_seen)
                check(!lane_a_p && lane_a_n && !lane_b_p && lane_b_n, "R7 dark",
                      {lane_a_p, lane_a_n, lane_b_p, lane_b_n}, 32'b0101);
            else
                check(lane_a_p == lane_c_p && lane_b_p == lane_c_p && lane_a_n == lane_c_n
                      && lane_b_n == lane_c_n, "R9 equal",
                      {lane_a_p, lane_b_p}, {lane_c_p, lane_c_p});
            if (idx == 9) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected character", 32'(cap), 0);
                end else begin
                    logic [9:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(cap == e, t, 32'(cap), 32'(e));
                end
                idx = 0;
            end else begin
                idx++;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!char_strobe && !lane_c_p, "R2 reset state", {char_strobe, lane_c_p}, 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        mon_on = 1;
        push(flip10(10'b0011111010), "R2 reset pad");
        // Encoded data, either enable, disparity tracking (R5, R3)
        send_enc(1'b0, 1'b1, 8'hBC, 1'b1, "R5 K28.5");
        send_enc(1'b1, 1'b0, 8'h00, 1'b0, "R5 D0.0");
        send_enc(1'b0, 1'b1, 8'hB5, 1'b0, "R5 D21.5");
        send_enc(1'b0, 1'b1, 8'hF1, 1'b0, "R5 D17.7");
        send_enc(1'b0, 1'b0, 8'h00, 1'b0, "R5 D0.0 other rd");
        // Idle: pads alternate (R4, R3)
        send_idle(1'b0, "R4 pad 1");
        send_idle(1'b0, "R4 pad 2");
        send_idle(1'b0, "R4 pad 3");
        // Enable held low: no pads (R3)
        for (int i = 0; i < 4; i++) send_enc(1'b0, 1'b1, (i % 2) ? 8'hB5 : 8'hF1, 1'b0, "R3 held enable");
        // Raw characters, disparity frozen, zero word (R6)
        send_raw(10'h155, "R6 raw");
        send_raw(10'h000, "R6 raw zero");
        send_raw(10'h000, "R6 raw zero");
        send_raw(10'h3FF, "R6 raw ones");
        send_idle(1'b1, "R6 first pad after raw");
        send_idle(1'b0, "R6 second pad after raw");
        // Blanking mid-character; lane C keeps framing (R7, R8, R9)
        send_enc(1'b0, 1'b1, 8'hF1, 1'b0, "R8 data under blank");
        repeat (3) @(negedge clk);
        blank_ab = 1'b1;
        send_enc(1'b0, 1'b1, 8'h00, 1'b0, "R8 data under blank");
        send_idle(1'b0, "R8 pad under blank");
        repeat (4) @(negedge clk);
        blank_ab = 1'b0;
        send_enc(1'b1, 1'b0, 8'hB5, 1'b0, "R9 after blank");
        send_idle(1'b0, "R4 drain");
        send_idle(1'b0, "R4 drain");
        while (exp_q.size() > 0) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog expired, queue=%0d expected=0", exp_q.size());
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule